// File: doc/BRIEF.md
# Address-Region Attribute Matcher

This block keeps a bank of eight memory address region descriptors together with one attribute byte per region, and classifies every 32-bit physical address presented on its lookup port. It reports whether the address lies inside any enabled region, which region was selected, and the caching and ordering attributes that apply to the access. The cache, bus and fetch logic around it use these results to steer each transaction.

Software programs the bank one byte at a time through an indexed configuration pair. A write to the index port (I/O address 0x22) selects a register number. The following read or write at the data port (0x23) then reaches that register. Each descriptor spans three consecutive index values. One byte holds start address bits 31..24, the next holds bits 23..16, and the third holds bits 15..12 in its upper nibble with a 4-bit logarithmic size code in its lower nibble. Lookup is purely combinational from the stored registers.

Top module: `addr_region_matcher`

## Requirements
- R1: A write to port 0x22 loads the index register. Reading port 0x22 returns the index, which holds its value through data-port accesses until port 0x22 is written again.
- R2: Region r's descriptor occupies index 0xC4+3r (start bits 31..24), 0xC5+3r (start bits 23..16) and 0xC6+3r (start bits 15..12 in bits 7..4, size code in bits 3..0). A data-port write stores the byte, and a data-port read returns it.
- R3: Region r's attribute byte sits at index 0xDC+r and stores bits 5..0. Bits 7..6 read back as zero.
- R4: A data-port write is ignored when the index lies outside 0xC4..0xE3, and a data-port read there returns 0x00. Reading any port other than 0x22 or 0x23 also returns 0x00.
- R5: Size code 0 disables a region, so the region never matches whatever its start address holds.
- R6: Size code c from 1 to 14 covers 2^(11+c) bytes. An address matches when its bits 31..(11+c) equal the same bits of the start address. Start bits below that boundary are ignored.
- R7: Size code 15 matches every 32-bit address.
- R8: Attribute bit 1 drives weak write ordering, bit 2 weak locking, bit 3 write gathering and bit 4 write-through. On a hit, the local-bus output is high unless bit 5 is set.
- R9: Attribute bit 0 is the cache bit. For regions 0..6, a set bit makes the hit uncacheable. For region 7, a set bit makes the hit cacheable and a clear bit makes it uncacheable.
- R10: When several enabled regions match, the lowest-numbered one supplies the region number and the attributes.
- R11: When no region matches, hit is 0, the region number is 0, cacheable is 1, and every other attribute output, local-bus included, is 0.
- R12: A data-port write changes lookup results only from the clock edge that captures it onward. Before that edge, lookups still see the old value.
- R13: Reset clears the index, all descriptors and all attribute bytes, so every address misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | Write strobe for the configuration port |
| io_port_i | input | 8 | I/O port address (0x22 index, 0x23 data) |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Combinational read data for io_port_i |
| lk_addr_i | input | 32 | Physical address to classify |
| lk_hit_o | output | 1 | Address lies in an enabled region |
| lk_region_o | output | 3 | Selected region number |
| lk_cacheable_o | output | 1 | Access may be cached |
| lk_weak_order_o | output | 1 | Weak write ordering permitted |
| lk_weak_lock_o | output | 1 | Weak locking permitted |
| lk_wr_gather_o | output | 1 | Write gathering permitted |
| lk_wr_through_o | output | 1 | Write-through policy |
| lk_local_bus_o | output | 1 | Local-bus access indication |

## Verification
The bench probes both edges of each size boundary: the last byte inside a region and the first byte outside it, at 4 KB, 64 KB, 1 MB and 32 MB granularity. An off-by-one in the size decoder would either extend a region by one block or cut it short. A start address that is deliberately misaligned catches a comparator that still looks at the low start bits. Overlapping regions catch a priority encoder that lets the higher number win. The inverted cache bit of the last region is tried in both states, so a copy-pasted polarity shows up as a flipped cacheable output. Out-of-range indices just below and just above the register window confirm that stray writes leave lookups intact. A lookup sampled before and after the capturing edge exposes a write path that is either transparent or one cycle late.

// File: rtl/arm_pkg.sv
package arm_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned DESC_BYTES = 3;
  localparam logic [3:0]  SIZE_OFF   = 4'd0;
  localparam logic [3:0]  SIZE_ALL   = 4'd15;

  // attribute byte as stored; field order gives bit 0 = cache_bit
  typedef struct packed {
    logic local_bus_off;
    logic wr_through;
    logic wr_gather;
    logic weak_lock;
    logic weak_order;
    logic cache_bit;
  } ctrl_t;

  typedef struct packed {
    logic cacheable;
    logic weak_order;
    logic weak_lock;
    logic wr_gather;
    logic wr_through;
    logic local_bus;
  } attr_t;

  localparam attr_t MISS_ATTR = '{cacheable: 1'b1, default: 1'b0};

  // compare mask for a size code; code 15 compares nothing
  function automatic logic [ADDR_W-1:0] size_mask(input logic [3:0] code);
    if (code == SIZE_ALL) return '0;
    return {ADDR_W{1'b1}} << (int'(code) + int'(PAGE_SHIFT) - 1);
  endfunction
endpackage

// File: rtl/arm_cfg_port.sv
module arm_cfg_port
  import arm_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned DESC_BASE   = 'hC4,
  parameter int unsigned CTRL_BASE   = 'hDC,
  parameter logic [7:0]  IDX_PORT    = 8'h22,
  parameter logic [7:0]  DATA_PORT   = 8'h23
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         io_wr_i,
  input  logic [7:0]                                   io_port_i,
  input  logic [7:0]                                   io_wdata_i,
  output logic [7:0]                                   io_rdata_o,
  output logic [NUM_REGIONS-1:0][DESC_BYTES-1:0][7:0]  desc_o,
  output ctrl_t [NUM_REGIONS-1:0]                      ctrl_o
);
  localparam int unsigned NUM_DESC_B = NUM_REGIONS * DESC_BYTES;

  logic [7:0]            index_q;
  logic                  idx_wr, data_wr;
  logic [NUM_DESC_B-1:0] desc_sel;
  logic [NUM_REGIONS-1:0] ctrl_sel;
  logic [7:0]            sel_byte;

  assign idx_wr  = io_wr_i && (io_port_i == IDX_PORT);
  assign data_wr = io_wr_i && (io_port_i == DATA_PORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     index_q <= '0;
    else if (idx_wr) index_q <= io_wdata_i;
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    for (genvar b = 0; b < DESC_BYTES; b++) begin : g_byte
      logic [7:0] byte_q;
      assign desc_sel[r*DESC_BYTES+b] = (index_q == 8'(DESC_BASE + DESC_BYTES*r + b));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                byte_q <= '0;
        else if (data_wr && desc_sel[r*DESC_BYTES+b]) byte_q <= io_wdata_i;
      end
      assign desc_o[r][b] = byte_q;
    end

    ctrl_t ctrl_q;
    assign ctrl_sel[r] = (index_q == 8'(CTRL_BASE + r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    ctrl_q <= '0;
      else if (data_wr && ctrl_sel[r]) ctrl_q <= ctrl_t'(io_wdata_i[$bits(ctrl_t)-1:0]);
    end
    assign ctrl_o[r] = ctrl_q;
  end

  always_comb begin
    sel_byte = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      for (int b = 0; b < DESC_BYTES; b++)
        if (desc_sel[r*DESC_BYTES+b]) sel_byte = desc_o[r][b];
      if (ctrl_sel[r]) sel_byte = 8'(ctrl_o[r]);
    end
  end

  always_comb begin
    if (io_port_i == IDX_PORT)       io_rdata_o = index_q;
    else if (io_port_i == DATA_PORT) io_rdata_o = sel_byte;
    else                             io_rdata_o = '0;
  end

  p_index_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> index_q == $past(io_wdata_i));
  p_index_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_wr |=> $stable(index_q));
  p_oob_write_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && desc_sel == '0 && ctrl_sel == '0) |=> ($stable(desc_o) && $stable(ctrl_o)));
  p_oob_read_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_port_i == DATA_PORT && desc_sel == '0 && ctrl_sel == '0) |-> io_rdata_o == 8'h00);
  p_ctrl_pad_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_port_i == DATA_PORT && ctrl_sel != '0) |-> io_rdata_o[7:6] == 2'b00);
endmodule

// File: rtl/arm_region_cmp.sv
module arm_region_cmp
  import arm_pkg::*;
#(
  parameter bit CACHE_BIT_ENABLES = 1'b0
) (
  input  logic [ADDR_W-1:0]          lk_addr_i,
  input  logic [DESC_BYTES-1:0][7:0] desc_i,
  input  ctrl_t                      ctrl_i,
  output logic                       match_o,
  output attr_t                      attr_o
);
  logic [ADDR_W-1:0] start, mask;
  logic [3:0]        size_code;
  logic              cacheable;

  assign start     = {desc_i[0], desc_i[1], desc_i[2][7:4], {PAGE_SHIFT{1'b0}}};
  assign size_code = desc_i[2][3:0];
  assign mask      = size_mask(size_code);
  assign match_o   = (size_code != SIZE_OFF) && (((lk_addr_i ^ start) & mask) == '0);

  if (CACHE_BIT_ENABLES) begin : g_cache_en
    assign cacheable = ctrl_i.cache_bit;
  end else begin : g_cache_dis
    assign cacheable = !ctrl_i.cache_bit;
  end

  assign attr_o = '{cacheable:  cacheable,
                    weak_order: ctrl_i.weak_order,
                    weak_lock:  ctrl_i.weak_lock,
                    wr_gather:  ctrl_i.wr_gather,
                    wr_through: ctrl_i.wr_through,
                    local_bus:  !ctrl_i.local_bus_off};

  always_comb begin
    if (desc_i[2][3:0] == 4'd15) p_full_space_r7: assert (match_o);
  end
endmodule

// File: rtl/arm_prio.sv
module arm_prio
  import arm_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned REG_W      = $clog2(NUM_REGIONS)
) (
  input  logic [NUM_REGIONS-1:0]  match_i,
  input  attr_t [NUM_REGIONS-1:0] attr_i,
  output logic                    hit_o,
  output logic [REG_W-1:0]        region_o,
  output attr_t                   attr_o
);
  always_comb begin
    hit_o    = 1'b0;
    region_o = '0;
    attr_o   = MISS_ATTR;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (match_i[r]) begin
        hit_o    = 1'b1;
        region_o = REG_W'(r);
        attr_o   = attr_i[r];
      end
    end
  end

  always_comb begin
    if (hit_o) begin
      p_sel_matches_r10: assert (match_i[region_o]);
      p_none_lower_r10:  assert ((match_i & ((NUM_REGIONS'(1) << region_o) - 1'b1)) == '0);
    end else begin
      p_miss_default_r11: assert (attr_o == MISS_ATTR && region_o == '0 && match_i == '0);
    end
  end
endmodule

// File: rtl/addr_region_matcher.sv
module addr_region_matcher
  import arm_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned DESC_BASE   = 'hC4,
  parameter int unsigned CTRL_BASE   = 'hDC,
  parameter logic [7:0]  IDX_PORT    = 8'h22,
  parameter logic [7:0]  DATA_PORT   = 8'h23
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           io_wr_i,
  input  logic [7:0]                     io_port_i,
  input  logic [7:0]                     io_wdata_i,
  output logic [7:0]                     io_rdata_o,
  input  logic [31:0]                    lk_addr_i,
  output logic                           lk_hit_o,
  output logic [$clog2(NUM_REGIONS)-1:0] lk_region_o,
  output logic                           lk_cacheable_o,
  output logic                           lk_weak_order_o,
  output logic                           lk_weak_lock_o,
  output logic                           lk_wr_gather_o,
  output logic                           lk_wr_through_o,
  output logic                           lk_local_bus_o
);
  logic [NUM_REGIONS-1:0][DESC_BYTES-1:0][7:0] desc;
  ctrl_t [NUM_REGIONS-1:0]                     ctrl;
  logic [NUM_REGIONS-1:0]                      match;
  attr_t [NUM_REGIONS-1:0]                     region_attr;
  attr_t                                       attr;

  arm_cfg_port #(
    .NUM_REGIONS(NUM_REGIONS), .DESC_BASE(DESC_BASE), .CTRL_BASE(CTRL_BASE),
    .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
  ) u_cfg (
    .clk_i, .rst_ni, .io_wr_i, .io_port_i, .io_wdata_i, .io_rdata_o,
    .desc_o(desc), .ctrl_o(ctrl)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    arm_region_cmp #(.CACHE_BIT_ENABLES(r == NUM_REGIONS - 1)) u_cmp (
      .lk_addr_i, .desc_i(desc[r]), .ctrl_i(ctrl[r]),
      .match_o(match[r]), .attr_o(region_attr[r])
    );
  end

  arm_prio #(.NUM_REGIONS(NUM_REGIONS)) u_prio (
    .match_i(match), .attr_i(region_attr),
    .hit_o(lk_hit_o), .region_o(lk_region_o), .attr_o(attr)
  );

  assign lk_cacheable_o  = attr.cacheable;
  assign lk_weak_order_o = attr.weak_order;
  assign lk_weak_lock_o  = attr.weak_lock;
  assign lk_wr_gather_o  = attr.wr_gather;
  assign lk_wr_through_o = attr.wr_through;
  assign lk_local_bus_o  = attr.local_bus;

  always_comb begin
    if (lk_hit_o) p_hit_enabled_r5: assert (desc[lk_region_o][2][3:0] != SIZE_OFF);
  end

  p_no_write_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> ($stable(lk_addr_i) ->
      $stable({lk_hit_o, lk_region_o, lk_cacheable_o, lk_weak_order_o, lk_weak_lock_o,
               lk_wr_gather_o, lk_wr_through_o, lk_local_bus_o})));
endmodule

// File: tb/addr_region_matcher_tb.sv
`timescale 1ns/1ps
module addr_region_matcher_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_port = 8'h00, io_wdata = 8'h00, io_rdata;
  logic [31:0] lk_addr = '0;
  logic        hit, cach, wo, wl, wg, wt, lb;
  logic [2:0]  region;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  addr_region_matcher u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(io_wr), .io_port_i(io_port),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .lk_addr_i(lk_addr),
    .lk_hit_o(hit), .lk_region_o(region), .lk_cacheable_o(cach),
    .lk_weak_order_o(wo), .lk_weak_lock_o(wl), .lk_wr_gather_o(wg),
    .lk_wr_through_o(wt), .lk_local_bus_o(lb)
  );

  // {addr, hit, region, cacheable, w_order, w_lock, gather, w_through, local_bus}
  localparam int NV = 13;
  localparam logic [41:0] VEC [NV] = '{
    {32'h1000_0000, 1'b1, 3'd0, 6'b010001},
    {32'h100F_FFFF, 1'b1, 3'd0, 6'b010001},
    {32'h1010_0000, 1'b1, 3'd1, 6'b100011},
    {32'h11FF_FFFF, 1'b1, 3'd1, 6'b100011},
    {32'h1200_0000, 1'b0, 3'd0, 6'b100000},
    {32'h2000_5ABC, 1'b1, 3'd2, 6'b101101},
    {32'h2000_6000, 1'b0, 3'd0, 6'b100000},
    {32'h2000_4FFF, 1'b0, 3'd0, 6'b100000},
    {32'h3000_0000, 1'b1, 3'd3, 6'b100000},
    {32'h3000_FFFF, 1'b1, 3'd3, 6'b100000},
    {32'h3001_0000, 1'b0, 3'd0, 6'b100000},
    {32'h0000_0000, 1'b0, 3'd0, 6'b100000},
    {32'hFFFF_FFFF, 1'b0, 3'd0, 6'b100000}
  };
  localparam logic [9:0] MISS = {1'b0, 3'd0, 6'b100000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk); io_port = port; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    io_write(8'h22, idx); io_write(8'h23, d);
  endtask

  task automatic io_read(input logic [7:0] port, output logic [7:0] d);
    io_port = port; #0.5; d = io_rdata;
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    io_write(8'h22, idx); io_read(8'h23, d);
  endtask

  task automatic look(input logic [31:0] a, output logic [9:0] r);
    lk_addr = a; #0.5; r = {hit, region, cach, wo, wl, wg, wt, lb};
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [9:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    io_read(8'h22, d);       chk("R13 index after reset", d, 8'h00);
    reg_read(8'hC4, d);      chk("R13 desc after reset", d, 8'h00);
    look(32'h1234_5678, r);  chk("R13 lookup after reset", r, MISS);

    // program regions 0..3
    reg_write(8'hC4, 8'h10); reg_write(8'hC5, 8'h00); reg_write(8'hC6, 8'h09);
    reg_write(8'hC7, 8'h10); reg_write(8'hC8, 8'h00); reg_write(8'hC9, 8'h0E);
    reg_write(8'hCA, 8'h20); reg_write(8'hCB, 8'h00); reg_write(8'hCC, 8'h51);
    reg_write(8'hCD, 8'h30); reg_write(8'hCE, 8'h00); reg_write(8'hCF, 8'h85);
    reg_write(8'hDC, 8'h03); reg_write(8'hDD, 8'h10);
    reg_write(8'hDE, 8'h0C); reg_write(8'hDF, 8'h20);

    // R6 R8 R9 R10 R11 vector walk
    for (int i = 0; i < NV; i++) begin
      look(VEC[i][41:10], r);
      chk($sformatf("R6/R8/R9/R10/R11 vector %0d", i), r, VEC[i][9:0]);
    end

    // R2 readback
    reg_read(8'hCA, d); chk("R2 readback start hi", d, 8'h20);
    reg_read(8'hCC, d); chk("R2 readback size byte", d, 8'h51);
    reg_read(8'hCF, d); chk("R2 readback misaligned byte", d, 8'h85);

    // R3 attribute pad bits
    reg_write(8'hE2, 8'hFF);
    reg_read(8'hE2, d); chk("R3 attribute pad", d, 8'h3F);

    // R1 index holds across data access
    reg_write(8'hCB, 8'h00);
    io_read(8'h22, d); chk("R1 index hold", d, 8'hCB);

    // R4 out-of-range indices
    reg_write(8'hC3, 8'hFF);
    io_read(8'h23, d);       chk("R4 read below window", d, 8'h00);
    look(32'h1000_0000, r);  chk("R4 lookup after stray write", r, VEC[0][9:0]);
    reg_write(8'hE4, 8'h0F);
    io_read(8'h23, d);       chk("R4 read above window", d, 8'h00);
    io_read(8'h22, d);       chk("R1 index readback", d, 8'hE4);
    look(32'h4000_0000, r);  chk("R4 no new region", r, MISS);
    io_read(8'h80, d);       chk("R4 unmapped port read", d, 8'h00);

    // R12 write visible only after capturing edge (region 4 full space)
    io_write(8'h22, 8'hD2);
    lk_addr = 32'h4000_0000;
    @(negedge clk); io_port = 8'h23; io_wdata = 8'h0F; io_wr = 1'b1;
    #0.5; chk("R12 before edge", hit, 1'b0);
    @(negedge clk); io_wr = 1'b0;
    look(32'h4000_0000, r);  chk("R12 after edge", r, {1'b1, 3'd4, 6'b100001});

    // R7 full space, R10 lower region still wins
    look(32'h0000_0000, r);  chk("R7 full space low", r, {1'b1, 3'd4, 6'b100001});
    look(32'hFFFF_FFFF, r);  chk("R7 full space high", r, {1'b1, 3'd4, 6'b100001});
    look(32'h1000_0000, r);  chk("R10 lower region wins", r, VEC[0][9:0]);
    look(32'h2000_5000, r);  chk("R10 region 2 over 4", r, VEC[5][9:0]);

    // R5 disable by size code 0
    reg_write(8'hD2, 8'h00);
    look(32'h4000_0000, r);  chk("R5 size zero disables", r, MISS);

    // R9 inverted cache bit on region 7
    reg_write(8'hDB, 8'h0F);
    look(32'h5000_0000, r);  chk("R9 region7 bit clear", r, {1'b1, 3'd7, 6'b000001});
    reg_write(8'hE3, 8'h01);
    look(32'h5000_0000, r);  chk("R9 region7 bit set", r, {1'b1, 3'd7, 6'b100001});

    // R13 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(32'h5000_0000, r);  chk("R13 lookup after re-reset", r, MISS);
    reg_read(8'hE3, d);      chk("R13 attribute after re-reset", d, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule